// File: doc/BRIEF.md
# Memory Instruction Reorder Eligibility Queue

This block keeps up to eight pending memory instructions in the order the processor sent them. It decides, every cycle, which of them may be performed ahead of older instructions that have not yet completed. Each slot holds an operation code, a primary address and, for fences, a secondary address. A slot is eligible when no older valid slot holds an instruction that conflicts with it. Which pairs conflict depends on the operation kinds, following a fixed per-kind rule set. Loads and stores also need their cache line to be present.

Each cycle the oldest eligible slot is presented on the issue outputs and removed at the next clock edge. The younger slots close the gap, so program order among the remaining entries is kept. New instructions enter through a valid/ready handshake. The cache side supplies one line-present bit per slot for the line that slot addresses. When a store issues early, the block raises a mark-dirty indication for its line.

Top module: `memop_issue_gate`

## Requirements
- R1: After reset the queue is empty: `in_ready` is 1, `iss_valid` is 0 and `elig_mask` is 0.
- R2: Opcode encoding is 0 load, 1 store, 2 commit, 3 reconcile, 4 read fence, 5 write fence. A load at address A is ineligible while any older valid slot is a store or a reconcile with primary address A.
- R3: A store at address A is ineligible while any older valid slot is a load or store with primary address A, or a write fence with secondary address A.
- R4: A commit at address A is ineligible while any older valid slot is a store with primary address A.
- R5: A reconcile at address A is ineligible while any older valid slot is a read fence with secondary address A.
- R6: A read fence with primary address A is ineligible while an older load to A is present. A write fence with primary address A is ineligible while an older commit to A is present.
- R7: `elig_mask` bit i is 1 only for a valid slot with no conflict. For a load or store in slot i, `line_hit[i]` must also be 1. The head slot never has an address conflict.
- R8: When `elig_mask` is non-zero, `iss_valid` is 1 and `iss_slot` is the lowest set bit. At most one slot issues per cycle. `iss_mark_dirty` is 1 exactly when the issued slot is a store.
- R9: The issued slot is removed at the clock edge, and all younger slots move down one place in the same cycle, keeping their relative order. `iss_op`, `iss_addr` and `iss_addr2` show the chosen slot's contents.
- R10: `in_ready` is 0 while all slots are valid, and an offered instruction is then not taken. An enqueue and an issue may happen in the same cycle, and the new entry goes behind the surviving entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | A free slot exists |
| in_op | input | 3 | Opcode of the offered instruction |
| in_addr | input | AW | Primary address |
| in_addr2 | input | AW | Secondary address (fences) |
| line_hit | input | DEPTH | Line present for the address held in each slot |
| elig_mask | output | DEPTH | Per-slot eligibility this cycle |
| iss_valid | output | 1 | A slot issues this cycle |
| iss_slot | output | log2(DEPTH) | Index of the issuing slot |
| iss_op | output | 3 | Opcode of the issuing slot |
| iss_addr | output | AW | Primary address of the issuing slot |
| iss_addr2 | output | AW | Secondary address of the issuing slot |
| iss_mark_dirty | output | 1 | The issuing store leaves its line dirty |

## Verification
The bench builds the block with its defaults: DEPTH of 8 and AW of 8. Random addresses are drawn from only four values, so the slots collide on addresses often. This exposes every per-kind conflict rule and chains of blockers deeper than one. The eight-slot depth allows the full-queue case, an offer refused while full, and an enqueue in the same cycle as an issue. It also allows hand-built chains in which each kind of instruction is held back by a different older kind.

// File: rtl/memop_pkg.sv
package memop_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_COMMIT  = 3'd2,
    OP_RECON   = 3'd3,
    OP_FENCE_R = 3'd4,
    OP_FENCE_W = 3'd5
  } mop_e;

  // Loads and stores may only proceed with their line present.
  function automatic logic needs_line(input logic [2:0] code);
    return (code == 3'(OP_LOAD)) || (code == 3'(OP_STORE));
  endfunction

endpackage

// File: rtl/memop_queue.sv
module memop_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [2:0]                 push_op,
  input  logic [AW-1:0]              push_a1,
  input  logic [AW-1:0]              push_a2,
  input  logic                       pop,
  input  logic [$clog2(DEPTH)-1:0]   pop_slot,
  output logic [DEPTH-1:0][2:0]      q_op,
  output logic [DEPTH-1:0][AW-1:0]   q_a1,
  output logic [DEPTH-1:0][AW-1:0]   q_a2,
  output logic [DEPTH-1:0]           q_vld,
  output logic                       full
);
  localparam int SW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]               cnt, n_cnt;
  logic [DEPTH-1:0][2:0]       n_op;
  logic [DEPTH-1:0][AW-1:0]    n_a1, n_a2;

  assign full = (cnt == CW'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_vld
    assign q_vld[i] = (CW'(i) < cnt);
  end

  // Close the gap left by the issued slot, then append behind the survivors.
  always_comb begin
    n_op  = q_op;
    n_a1  = q_a1;
    n_a2  = q_a2;
    n_cnt = cnt;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (SW'(i) >= pop_slot) begin
          n_op[i] = q_op[i+1];
          n_a1[i] = q_a1[i+1];
          n_a2[i] = q_a2[i+1];
        end
      end
      n_cnt = n_cnt - CW'(1);
    end
    if (push) begin
      n_op[n_cnt[SW-1:0]] = push_op;
      n_a1[n_cnt[SW-1:0]] = push_a1;
      n_a2[n_cnt[SW-1:0]] = push_a2;
      n_cnt = n_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      q_op <= '0;
      q_a1 <= '0;
      q_a2 <= '0;
    end else begin
      cnt  <= n_cnt;
      q_op <= n_op;
      q_a1 <= n_a1;
      q_a2 <= n_a2;
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r10_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt == $past(cnt) + CW'(1)));

  a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt == $past(cnt) - CW'(1)));

  a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  a_r9_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && ((CW'(pop_slot) + CW'(1)) < cnt))
      |=> (q_a1[$past(pop_slot)] == $past(q_a1[pop_slot + SW'(1)]))
       && (q_op[$past(pop_slot)] == $past(q_op[pop_slot + SW'(1)])));

endmodule

// File: rtl/memop_elig.sv
module memop_elig
  import memop_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0][2:0]     q_op,
  input  logic [DEPTH-1:0][AW-1:0]  q_a1,
  input  logic [DEPTH-1:0][AW-1:0]  q_a2,
  input  logic [DEPTH-1:0]          q_vld,
  input  logic [DEPTH-1:0]          line_hit,
  output logic [DEPTH-1:0]          elig
);

  // Does an older instruction hold back a younger one?
  function automatic logic older_blocks(
    input logic [2:0]    ycode,
    input logic [AW-1:0] ya,
    input logic [2:0]    ocode,
    input logic [AW-1:0] oa,
    input logic [AW-1:0] ob
  );
    mop_e y;
    mop_e o;
    y = mop_e'(ycode);
    o = mop_e'(ocode);
    case (y)
      OP_LOAD:    return ((o == OP_STORE) || (o == OP_RECON)) && (oa == ya);
      OP_STORE:   return (((o == OP_LOAD) || (o == OP_STORE)) && (oa == ya))
                      || ((o == OP_FENCE_W) && (ob == ya));
      OP_COMMIT:  return (o == OP_STORE) && (oa == ya);
      OP_RECON:   return (o == OP_FENCE_R) && (ob == ya);
      OP_FENCE_R: return (o == OP_LOAD) && (oa == ya);
      OP_FENCE_W: return (o == OP_COMMIT) && (oa == ya);
      default:    return 1'b0;
    endcase
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic blocked;
    logic ok;
    always_comb begin
      blocked = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (q_vld[j] && older_blocks(q_op[i], q_a1[i], q_op[j], q_a1[j], q_a2[j]))
          blocked = 1'b1;
      end
      ok = q_vld[i] && !blocked && (!needs_line(q_op[i]) || line_hit[i]);
    end
    assign elig[i] = ok;
  end

  // R7: the head has no address conflict; only a missing line can hold it.
  a_r7_head_free: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld[0] && (!needs_line(q_op[0]) || line_hit[0])) |-> elig[0]);

  // R2: a load directly behind a store to the same address waits.
  a_r2_load_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld[1] && q_op[1] == 3'(OP_LOAD) && q_op[0] == 3'(OP_STORE)
      && q_a1[0] == q_a1[1]) |-> !elig[1]);

  a_r7_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (elig & ~q_vld) == '0);

endmodule

// File: rtl/memop_pick.sv
module memop_pick #(
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          elig,
  output logic                      any,
  output logic [$clog2(DEPTH)-1:0]  idx,
  output logic [DEPTH-1:0]          grant
);
  localparam int SW = $clog2(DEPTH);

  function automatic logic [SW-1:0] first_set(input logic [DEPTH-1:0] m);
    logic [SW-1:0] r;
    r = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (m[k]) r = SW'(k);
    end
    return r;
  endfunction

  assign any   = |elig;
  assign idx   = first_set(elig);
  assign grant = any ? (DEPTH'(1) << idx) : '0;

  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r8_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((grant & elig) != '0));

  a_r8_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((elig & (grant - DEPTH'(1))) == '0));

endmodule

// File: rtl/memop_issue_gate.sv
module memop_issue_gate
  import memop_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [2:0]                in_op,
  input  logic [AW-1:0]             in_addr,
  input  logic [AW-1:0]             in_addr2,
  input  logic [DEPTH-1:0]          line_hit,
  output logic [DEPTH-1:0]          elig_mask,
  output logic                      iss_valid,
  output logic [$clog2(DEPTH)-1:0]  iss_slot,
  output logic [2:0]                iss_op,
  output logic [AW-1:0]             iss_addr,
  output logic [AW-1:0]             iss_addr2,
  output logic                      iss_mark_dirty
);
  localparam int SW = $clog2(DEPTH);

  logic [DEPTH-1:0][2:0]       q_op;
  logic [DEPTH-1:0][AW-1:0]    q_a1, q_a2;
  logic [DEPTH-1:0]            q_vld;
  logic                        q_full;
  logic                        ev_push;
  logic                        ev_pop;
  logic [SW-1:0]               pick_idx;
  logic [DEPTH-1:0]            pick_grant;

  assign in_ready = !q_full;
  assign ev_push  = in_valid && in_ready;

  memop_queue #(.DEPTH(DEPTH), .AW(AW)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ev_push),
    .push_op  (in_op),
    .push_a1  (in_addr),
    .push_a2  (in_addr2),
    .pop      (ev_pop),
    .pop_slot (pick_idx),
    .q_op     (q_op),
    .q_a1     (q_a1),
    .q_a2     (q_a2),
    .q_vld    (q_vld),
    .full     (q_full)
  );

  memop_elig #(.DEPTH(DEPTH), .AW(AW)) u_elig (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_op     (q_op),
    .q_a1     (q_a1),
    .q_a2     (q_a2),
    .q_vld    (q_vld),
    .line_hit (line_hit),
    .elig     (elig_mask)
  );

  memop_pick #(.DEPTH(DEPTH)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig_mask),
    .any   (ev_pop),
    .idx   (pick_idx),
    .grant (pick_grant)
  );

  assign iss_valid      = ev_pop;
  assign iss_slot       = pick_idx;
  assign iss_op         = q_op[pick_idx];
  assign iss_addr       = q_a1[pick_idx];
  assign iss_addr2      = q_a2[pick_idx];
  assign iss_mark_dirty = ev_pop && (iss_op == 3'(OP_STORE));

  a_r7_line_present: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && needs_line(iss_op)) |-> line_hit[iss_slot]);

  a_r8_dirty_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    iss_mark_dirty |-> (iss_valid && iss_op == 3'(OP_STORE)));

  a_r9_issue_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> q_vld[iss_slot]);

  a_r8_grant_matches: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> pick_grant[iss_slot]);

endmodule

// File: tb/memop_issue_gate_test.sv
module memop_issue_gate_test;
  localparam int D  = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [2:0]    in_op;
  logic [AW-1:0] in_addr, in_addr2;
  logic [D-1:0]  line_hit;
  logic [D-1:0]  elig_mask;
  logic          iss_valid;
  logic [2:0]    iss_slot;
  logic [2:0]    iss_op;
  logic [AW-1:0] iss_addr, iss_addr2;
  logic          iss_mark_dirty;

  int n_checks = 0;
  int n_fail   = 0;
  int m_op[D];
  int m_a[D];
  int m_b[D];
  int m_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  memop_issue_gate #(.DEPTH(D), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .in_addr2(in_addr2), .line_hit(line_hit),
    .elig_mask(elig_mask), .iss_valid(iss_valid), .iss_slot(iss_slot),
    .iss_op(iss_op), .iss_addr(iss_addr), .iss_addr2(iss_addr2),
    .iss_mark_dirty(iss_mark_dirty)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Rules grouped by the kind of the older instruction.
  function automatic bit held_by(int oop, int oa, int ob, int yop, int ya);
    case (oop)
      0: return (yop == 1 || yop == 4) && oa == ya;
      1: return (yop == 0 || yop == 1 || yop == 2) && oa == ya;
      2: return yop == 5 && oa == ya;
      3: return yop == 0 && oa == ya;
      4: return yop == 3 && ob == ya;
      5: return yop == 1 && ob == ya;
      default: return 0;
    endcase
  endfunction

  function automatic logic [D-1:0] model_elig(logic [D-1:0] hit);
    logic [D-1:0] r;
    r = '0;
    for (int i = 0; i < m_cnt; i++) begin
      bit free;
      free = 1;
      for (int j = 0; j < i; j++)
        if (held_by(m_op[j], m_a[j], m_b[j], m_op[i], m_a[i])) free = 0;
      if ((m_op[i] == 0 || m_op[i] == 1) && !hit[i]) free = 0;
      r[i] = free;
    end
    return r;
  endfunction

  task automatic step(input bit v, input int op, input int a, input int b,
                      input logic [D-1:0] hit, input int lit = -1,
                      input string ltag = "");
    logic [D-1:0] em;
    int win;
    bit acc;
    @(negedge clk);
    in_valid = v; in_op = op[2:0]; in_addr = a[AW-1:0];
    in_addr2 = b[AW-1:0]; line_hit = hit;
    #1;
    em  = model_elig(hit);
    acc = v && (m_cnt < D);
    win = 0;
    for (int k = D - 1; k >= 0; k--) if (em[k]) win = k;
    if (lit >= 0) check(elig_mask == lit[D-1:0], ltag, int'(elig_mask), lit);
    check(in_ready == (m_cnt < D), "R10 ready", int'(in_ready), int'(m_cnt < D));
    check(elig_mask == em, "R7 elig_mask", int'(elig_mask), int'(em));
    check(iss_valid == (em != 0), "R8 iss_valid", int'(iss_valid), int'(em != 0));
    if (em != 0) begin
      check(iss_slot == win[2:0], "R8 oldest slot", int'(iss_slot), win);
      check(iss_op == m_op[win][2:0], "R9 iss_op", int'(iss_op), m_op[win]);
      check(iss_addr == m_a[win][AW-1:0], "R9 iss_addr", int'(iss_addr), m_a[win]);
      check(iss_addr2 == m_b[win][AW-1:0], "R9 iss_addr2", int'(iss_addr2), m_b[win]);
      check(iss_mark_dirty == (m_op[win] == 1), "R8 dirty", int'(iss_mark_dirty),
            int'(m_op[win] == 1));
    end else begin
      check(iss_mark_dirty == 0, "R8 dirty idle", int'(iss_mark_dirty), 0);
    end
    @(posedge clk);
    if (em != 0) begin
      for (int k = win; k < D - 1; k++) begin
        m_op[k] = m_op[k+1]; m_a[k] = m_a[k+1]; m_b[k] = m_b[k+1];
      end
      m_cnt--;
    end
    if (acc) begin
      m_op[m_cnt] = op; m_a[m_cnt] = a; m_b[m_cnt] = b;
      m_cnt++;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && m_cnt > 0; k++) step(0, 0, 0, 0, '1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    rst_n = 0; in_valid = 0; in_op = 0; in_addr = 0; in_addr2 = 0; line_hit = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(in_ready == 1, "R1 ready", int'(in_ready), 1);
    check(iss_valid == 0, "R1 iss_valid", int'(iss_valid), 0);
    check(elig_mask == 0, "R1 elig", int'(elig_mask), 0);

    // R7: head load waits for its line, then goes.
    step(1, 0, 1, 0, '0);
    step(0, 0, 0, 0, 8'h00, 0, "R7 head load no line");
    step(0, 0, 0, 0, 8'h01, 1, "R7 head load line present");
    drain();

    // R8: two free loads, oldest issues first.
    step(1, 0, 1, 0, '0);
    step(1, 0, 2, 0, '0);
    step(0, 0, 0, 0, 8'h03, 3, "R8 both eligible");
    drain();

    // R2/R5/R6 chain: load, read fence, reconcile, load, store, free load.
    step(1, 0, 3, 0, '0);
    step(1, 4, 3, 5, '0);
    step(1, 3, 5, 0, '0);
    step(1, 0, 5, 0, '0);
    step(1, 1, 3, 0, '0);
    step(1, 0, 6, 0, '0);
    step(0, 0, 0, 0, 8'h3E, 8'h20, "R2/R3/R5/R6 read chain");
    drain();

    // R3/R4/R6 chain: store, commit, write fence, stores, load.
    step(1, 1, 4, 0, '0);
    step(1, 2, 4, 0, '0);
    step(1, 5, 4, 7, '0);
    step(1, 1, 7, 0, '0);
    step(1, 1, 4, 0, '0);
    step(1, 1, 8, 0, '0);
    step(1, 0, 8, 0, '0);
    step(0, 0, 0, 0, 8'h7E, 8'h20, "R3/R4/R6 write chain");
    drain();

    // R10: fill, refuse, then enqueue during an issue.
    for (int k = 0; k < D; k++) step(1, 0, 16 + k, 0, '0);
    step(1, 2, 9, 0, '0);
    check(in_ready == 0, "R10 full ready", int'(in_ready), 0);
    step(0, 0, 0, 0, 8'h01);
    step(1, 1, 2, 0, 8'h01);
    step(1, 2, 2, 0, 8'h00);
    drain();

    // Random traffic with a narrow address range.
    seed = $urandom(32'd4242);
    for (int n = 0; n < 4000; n++) begin
      int ph;
      logic [D-1:0] h;
      ph = n / 1000;
      h  = (ph == 1) ? D'($urandom) & D'($urandom) : D'($urandom) | D'($urandom);
      step(($urandom % 4) < ((ph == 2) ? 1 : 3), int'($urandom % 6),
           int'($urandom % 4), int'($urandom % 4), h);
    end
    drain();

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule